// File: doc/BRIEF.md
# Fixed-Priority Eight-Line Interrupt Controller

The controller gathers eight interrupt request lines and drives one interrupt line to a processor. A request takes part only when its line is not masked and its priority is above every input currently in service. Line 0 ranks highest and line 7 lowest. The processor answers with two acknowledge strobes. On the second strobe the controller returns a vector byte and marks the chosen input as in service.

Each line can be triggered by an edge or by its level. In edge mode a per-line arming latch lets a line raise one request per low-to-high transition. A line that stays high after being serviced stays silent until it has gone low again. In level mode the request simply follows the line.

Software uses a small synchronous register port. Through it, software selects the trigger mode, turns automatic end-of-interrupt on or off, sets a 5-bit vector base and masks lines. It also issues a non-specific end-of-interrupt and reads back the request and in-service bits.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all eight lines are masked, edge mode and manual end-of-interrupt are selected, the vector base is 0, the request and in-service registers read 0 and `intr_out` is low.
- R2: The vector byte is valid while `inta` is high on the second strobe. Bits 7:3 hold the programmed base and bits 2:0 hold the winning line number. When several eligible lines are pending, the lowest-numbered one wins.
- R3: `intr_out` is high from the cycle after an eligible request is registered, stays high between the two strobes, and reflects only remaining eligible requests from the cycle after the second strobe.
- R4: In edge mode, a line that is held high raises exactly one request. It can request again only after it has been sampled low for at least one cycle.
- R5: In level mode the request bit follows the line one cycle later. A line still high raises `intr_out` again as soon as its in-service bit clears.
- R6: While an in-service bit is set, requests of equal or lower priority do not raise `intr_out`. A higher-priority request does.
- R7: Writing 1 to bit 0 at address 2 clears the highest-priority in-service bit that is set (the lowest index).
- R8: With automatic end-of-interrupt enabled, no in-service bit is set on acknowledge. A pending lower-priority request then raises `intr_out` again at once.
- R9: A masked line still sets its request bit, which is readable, but it never raises `intr_out`. Unmasking it lets it compete.
- R10: If no eligible request exists at the second strobe, the vector carries line number 7 and no in-service bit is set.
- R11: Register map:
  - Address 0 is control: bit 0 selects level mode, bit 1 enables automatic end-of-interrupt, and bits 7:3 hold the vector base. Bit 2 reads 0.
  - Address 1 is the mask register, where 1 means masked.
  - Writes to address 2 are commands. Reads of address 2 return the request register.
  - Reads of address 3 return the in-service register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines, line 0 highest |
| inta | input | 1 | Acknowledge strobe, one cycle per strobe |
| intr_out | output | 1 | Interrupt line to the processor |
| vec_out | output | 8 | Vector byte |
| vec_valid | output | 1 | High during the second acknowledge strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data for `rd_addr` |

## Verification
A stuck or wrongly cleared arming latch shows up as a missing or duplicate `intr_out` one cycle after the line changes. A stray or missing in-service bit changes which later requests may interrupt. It is visible at the next request of equal or higher priority and in the address 3 readback. A wrong acknowledge phase shows at once as a vector on the wrong strobe. The bench's reference model therefore compares `intr_out` on every cycle and compares the vector on every second strobe, so any such fault appears within a cycle or two of the stimulus that exposes it.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_in,
  input  logic       inta,
  output logic       intr_out,
  output logic [7:0] vec_out,
  output logic       vec_valid,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam int N = 8;

  logic [N-1:0] irr, isr, mask, arm, grant, elig, eoi_bit;
  logic [4:0]   base;
  logic         level_mode, auto_eoi, ph, found, req_ok;
  logic [2:0]   pb;
  logic [3:0]   hs;

  wire ctrl_wr = wr_en && wr_addr == 2'd0;
  wire mask_wr = wr_en && wr_addr == 2'd1;
  wire eoi_cmd = wr_en && wr_addr == 2'd2 && wr_data[0];

  assign elig    = irr & ~mask;
  assign eoi_bit = isr & (~isr + 8'd1);

  always_comb begin
    pb = 3'd7;
    found = 1'b0;
    hs = 4'd8;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        pb = 3'(i);
        found = 1'b1;
      end
      if (isr[i]) hs = 4'(i);
    end
    req_ok = found && ({1'b0, pb} < hs);
  end

  assign vec_valid = inta && ph;
  assign vec_out   = {base, req_ok ? pb : 3'd7};
  assign intr_out  = ph || req_ok;
  assign grant     = (vec_valid && req_ok) ? (8'd1 << pb) : 8'd0;

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {base, 1'b0, auto_eoi, level_mode};
      2'd1:    rd_data = mask;
      2'd2:    rd_data = irr;
      default: rd_data = isr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask       <= '1;
      level_mode <= 1'b0;
      auto_eoi   <= 1'b0;
      base       <= '0;
      irr        <= '0;
      isr        <= '0;
      arm        <= '0;
      ph         <= 1'b0;
    end else begin
      if (inta) ph <= ~ph;
      arm <= ~irq_in | (arm & ~grant);
      irr <= level_mode ? irq_in : ((irr | (irq_in & arm)) & ~grant);
      isr <= (isr & ~(eoi_cmd ? eoi_bit : 8'd0)) | (auto_eoi ? 8'd0 : grant);
      if (ctrl_wr) begin
        level_mode <= wr_data[0];
        auto_eoi   <= wr_data[1];
        base       <= wr_data[7:3];
      end
      if (mask_wr) mask <= wr_data;
    end
  end

  AST_ISR_SET_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && req_ok && !auto_eoi && !eoi_cmd) |=> isr[$past(vec_out[2:0])]); // R2
  AST_AEOI_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && auto_eoi && !eoi_cmd && !ctrl_wr) |=> isr == $past(isr)); // R8
  AST_SPURIOUS_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !req_ok && !eoi_cmd) |=> isr == $past(isr)); // R10
  AST_EOI_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_cmd && isr != 8'd0 && !vec_valid) |=> $countones(isr) == $countones($past(isr)) - 1); // R7

  for (genvar g = 0; g < N; g++) begin : g_line
    AST_EDGE_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_mode && !ctrl_wr && !arm[g] && !irr[g]) |=> !irr[g]); // R4
  end
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, inta = 0, wr_en = 0;
  logic [7:0] irq_in = 0, wr_data = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic intr_out, vec_valid;
  logic [7:0] vec_out, rd_data;
  int checks = 0, failures = 0, cycles = 0;

  irq_prio_ctrl dut_i (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .inta(inta),
    .intr_out(intr_out), .vec_out(vec_out), .vec_valid(vec_valid), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference model
  bit m_irr[8], m_isr[8], m_mask[8], m_arm[8];
  bit m_level, m_aeoi, m_ph;
  int m_base;

  function automatic void m_resolve(output bit ok, output int win);
    int hi = 8;
    win = -1;
    for (int i = 7; i >= 0; i--) begin
      if (m_isr[i]) hi = i;
      if (m_irr[i] && !m_mask[i]) win = i;
    end
    ok = (win >= 0) && (win < hi);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_irr[i] = 0; m_isr[i] = 0; m_mask[i] = 1; m_arm[i] = 0;
      end
      m_level = 0; m_aeoi = 0; m_ph = 0; m_base = 0;
    end else begin
      bit ok; int win; int g;
      m_resolve(ok, win);
      g = (inta && m_ph && ok) ? win : -1;
      if (wr_en && wr_addr == 2 && wr_data[0]) begin
        for (int i = 0; i < 8; i++) if (m_isr[i]) begin m_isr[i] = 0; break; end
      end
      if (g >= 0 && !m_aeoi) m_isr[g] = 1;
      for (int i = 0; i < 8; i++) begin
        if (m_level) m_irr[i] = irq_in[i];
        else if (i == g) m_irr[i] = 0;
        else if (irq_in[i] && m_arm[i]) m_irr[i] = 1;
        if (!irq_in[i]) m_arm[i] = 1;
        else if (i == g) m_arm[i] = 0;
      end
      if (inta) m_ph = !m_ph;
      if (wr_en && wr_addr == 0) begin
        m_level = wr_data[0]; m_aeoi = wr_data[1]; m_base = wr_data[7:3];
      end
      if (wr_en && wr_addr == 1) for (int i = 0; i < 8; i++) m_mask[i] = wr_data[i];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #(CLK_P/4);
    if (rst_n) begin
      bit ok; int win; int ev;
      m_resolve(ok, win);
      chk(intr_out == (m_ph || ok), "R3 R6 model intr_out", intr_out, m_ph || ok);
      chk(vec_valid == (inta && m_ph), "R2 model vec_valid", vec_valid, inta && m_ph);
      if (inta && m_ph) begin
        ev = m_base * 8 + (ok ? win : 7);
        chk(vec_out == ev, "R2 R10 model vector", vec_out, ev);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq_in = v;
  endtask
  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_addr = a; #(CLK_P/4);
    chk(rd_data == exp, tag, rd_data, exp);
  endtask
  task automatic chk_intr(input logic exp, input string tag);
    @(negedge clk); #(CLK_P/4);
    chk(intr_out == exp, tag, intr_out, exp);
  endtask
  task automatic ack1;
    @(negedge clk); inta = 1;
    @(negedge clk); inta = 0;
  endtask
  task automatic ack2(input logic [7:0] exp, input string tag);
    @(negedge clk); inta = 1; #(CLK_P/4);
    chk(vec_out == exp, tag, vec_out, exp);
    @(negedge clk); inta = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", cycles, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, 8'h00, "R1 control after reset");
    rd(1, 8'hFF, "R1 mask after reset");
    rd(2, 8'h00, "R1 request after reset");
    rd(3, 8'h00, "R1 in-service after reset");
    chk_intr(0, "R1 intr low after reset");

    wr(0, 8'hA0);
    rd(0, 8'hA0, "R11 control readback");
    wr(1, 8'h00);
    set_irq(8'h28);
    chk_intr(1, "R3 intr on request");
    ack1; ack2(8'hA3, "R2 lowest line wins");
    rd(3, 8'h08, "R2 in-service bit set");
    chk_intr(0, "R6 lower request held off");
    rd(2, 8'h20, "R4 edge request consumed");
    set_irq(8'h2A);
    chk_intr(1, "R6 higher request interrupts");
    ack1; ack2(8'hA1, "R6 nested vector");
    rd(3, 8'h0A, "R6 nested in-service");
    wr(2, 8'h01);
    rd(3, 8'h08, "R7 eoi clears highest");
    wr(2, 8'h01);
    rd(3, 8'h00, "R7 second eoi");
    chk_intr(1, "R6 pending lower released");
    ack1; ack2(8'hA5, "R2 vector line 5");
    wr(2, 8'h01);
    chk_intr(0, "R4 held lines do not rerequest");
    rd(2, 8'h00, "R4 request register clear");
    set_irq(8'h00);
    set_irq(8'h08);
    chk_intr(1, "R4 rearmed after low");
    ack1; ack2(8'hA3, "R4 rearmed vector");
    wr(2, 8'h01);
    set_irq(8'h00);

    wr(1, 8'h04);
    set_irq(8'h04);
    chk_intr(0, "R9 masked line silent");
    rd(2, 8'h04, "R9 masked request kept");
    wr(1, 8'h00);
    chk_intr(1, "R9 unmasked competes");
    ack1; ack2(8'hA2, "R9 vector after unmask");
    wr(2, 8'h01);
    set_irq(8'h00);

    wr(0, 8'hA1);
    set_irq(8'h10);
    chk_intr(1, "R5 level request");
    ack1; ack2(8'hA4, "R5 level vector");
    chk_intr(0, "R6 equal priority held off");
    wr(2, 8'h01);
    chk_intr(1, "R5 level re-request after eoi");
    ack1; ack2(8'hA4, "R5 second level vector");
    wr(2, 8'h01);
    set_irq(8'h00);
    rd(2, 8'h00, "R5 request follows line low");

    set_irq(8'h40);
    ack1;
    set_irq(8'h00);
    repeat (2) @(negedge clk);
    ack2(8'hA7, "R10 spurious vector");
    rd(3, 8'h00, "R10 no in-service on spurious");
    chk_intr(0, "R10 intr low after spurious");

    wr(0, 8'hA2);
    set_irq(8'h44);
    chk_intr(1, "R8 request in auto mode");
    ack1; ack2(8'hA2, "R8 first vector");
    rd(3, 8'h00, "R8 no in-service bit");
    chk_intr(1, "R8 lower reasserts");
    ack1; ack2(8'hA6, "R8 lower vector");
    chk_intr(0, "R8 intr low when drained");
    set_irq(8'h00);
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) cycles++;
endmodule